// File: doc/BRIEF.md
# Result Bus Arbiter with Unit Occupancy

This block sits at the completion end of an out-of-order core. Each non-pipelined functional unit tells it when an instruction starts and when that instruction finishes executing. A finishing instruction carries a program-order sequence tag and a flag that says whether it produces a result. A single shared result broadcast bus is granted to at most one unit per cycle, and the oldest finished instruction by tag wins.

A unit whose instruction has finished but has not yet broadcast stays occupied, along with the reservation station feeding it. Operations with no result, such as stores and branches, release their unit directly. The block gives the dispatcher two free indications per unit:
- **Structural free**: an instruction that only waited for the unit may start in the broadcast cycle itself.
- **Bus free**: an instruction that must capture the broadcast value may start from the following cycle.

Each unit runs its own state machine:
- **UNIT_IDLE**: the unit is free. It goes to UNIT_EXEC on a start.
- **UNIT_EXEC**: an instruction is executing.
  - On a finish with result it goes to UNIT_WAIT and latches the tag.
  - On a finish without result it goes to UNIT_IDLE.
- **UNIT_WAIT**: the finished instruction holds the unit.
  - On its grant it goes to UNIT_IDLE.
  - On its grant together with a start it goes straight back to UNIT_EXEC.

Top module: `result_bus_arbiter`

## Requirements
- R1: At most one bit of `grant_o` is set in any cycle, and `bus_valid_o` is high exactly when one bit is set.
- R2: Among waiting units, the grant goes to the oldest tag. Tag a is older than tag b when bit TAG_W-1 of (a - b) mod 2^TAG_W is 1. Equal tags go to the lower unit index. A unit not granted keeps waiting and is granted in a later cycle.
- R3: Take a unit that receives `done_i` with `need_bus_i`=1 while executing. From the next cycle until its grant cycle, both of its free outputs are 0.
- R4: Take a unit that receives `done_i` with `need_bus_i`=0 while executing. It never asks for the bus, and both of its free outputs are 1 in the next cycle.
- R5: The grant is registered. It appears at the earliest in the cycle after the unit enters the waiting state. In the grant cycle, `bus_tag_o` carries the unit's latched tag, `free_struct_o` of the unit is 1 and `free_bus_o` is 0. In the following cycle `free_bus_o` is 1 and the grant is gone.
- R6: A `start_i` on a unit in its grant cycle is accepted. In the next cycle the unit is busy again, with both free outputs at 0 and no grant.
- R7: A `start_i` on a unit whose `free_struct_o` is 0 is ignored. A waiting unit that receives one still wins the bus later.
- R8: A synchronous active-high `rst` clears every unit to free, and `grant_o` and `bus_valid_o` to 0, from the cycle after it is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | N_UNITS | Dispatcher starts an instruction on a unit |
| done_i | input | N_UNITS | Unit's instruction finishes executing this cycle |
| need_bus_i | input | N_UNITS | Finishing instruction produces a bus result |
| tag_i | input | N_UNITS*TAG_W | Sequence tag per unit, unit u in bits [u*TAG_W +: TAG_W] |
| grant_o | output | N_UNITS | One-hot registered bus grant |
| bus_valid_o | output | 1 | The bus carries a broadcast this cycle |
| bus_tag_o | output | TAG_W | Tag of the broadcasting instruction |
| free_struct_o | output | N_UNITS | Unit may accept an instruction with no bus operand |
| free_bus_o | output | N_UNITS | Unit may accept an instruction that reads the bus |

## Verification
On every cycle, assertions check the following:
- the grant stays one-hot or empty;
- a grant lands only on a waiting unit;
- a unit finishing without a result returns to idle;
- a granted unit leaves the waiting state on the next edge;
- reset clears the grant.

The age ordering across wraparound, the equal-tag tie-break, the cycle in which each free output rises, and the ignored start on a waiting unit can only be shown by the bench's scenarios. These scenarios compare whole grant sequences with orders worked out from the tags.

// File: rtl/rba_pkg.sv
package rba_pkg;
    typedef enum logic [1:0] {
        UNIT_IDLE = 2'd0,
        UNIT_EXEC = 2'd1,
        UNIT_WAIT = 2'd2
    } unit_state_e;
endpackage

// File: rtl/rba_unit.sv
module rba_unit
    import rba_pkg::*;
#(
    parameter int TAG_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             done_i,
    input  logic             need_bus_i,
    input  logic [TAG_W-1:0] tag_i,
    input  logic             grant_i,
    output logic             waiting_o,
    output logic [TAG_W-1:0] tag_o,
    output logic             free_struct_o,
    output logic             free_bus_o
);
    unit_state_e state_q, state_d;
    logic [TAG_W-1:0] tag_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            UNIT_IDLE: if (start_i) state_d = UNIT_EXEC;
            UNIT_EXEC: if (done_i)  state_d = need_bus_i ? UNIT_WAIT : UNIT_IDLE;
            UNIT_WAIT: if (grant_i) state_d = start_i ? UNIT_EXEC : UNIT_IDLE;
            default:                state_d = UNIT_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= UNIT_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tag_q <= '0;
        end else if (state_q == UNIT_EXEC && done_i && need_bus_i) begin
            tag_q <= tag_i;
        end
    end

    always_comb begin
        waiting_o     = (state_q == UNIT_WAIT);
        tag_o         = tag_q;
        free_bus_o    = (state_q == UNIT_IDLE);
        free_struct_o = (state_q == UNIT_IDLE) || ((state_q == UNIT_WAIT) && grant_i);
    end

    // R2
    grant_on_waiter_chk: assert property (@(posedge clk) disable iff (rst)
        grant_i |-> (state_q == UNIT_WAIT));

    // R4
    no_result_release_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == UNIT_EXEC && done_i && !need_bus_i) |=> (state_q == UNIT_IDLE));

    // R5
    grant_leaves_wait_chk: assert property (@(posedge clk) disable iff (rst)
        (grant_i && !start_i) |=> (state_q == UNIT_IDLE));
endmodule

// File: rtl/rba_oldest_pick.sv
module rba_oldest_pick #(
    parameter int N_UNITS = 4,
    parameter int TAG_W   = 4
) (
    input  logic [N_UNITS-1:0]       req_i,
    input  logic [N_UNITS*TAG_W-1:0] tags_i,
    output logic [N_UNITS-1:0]       pick_o
);
    localparam int IDX_W = (N_UNITS > 1) ? $clog2(N_UNITS) : 1;

    function automatic logic is_older(input logic [TAG_W-1:0] a, input logic [TAG_W-1:0] b);
        logic [TAG_W-1:0] diff;
        diff = a - b;
        return diff[TAG_W-1];
    endfunction

    logic             found;
    logic [IDX_W-1:0] best_idx;
    logic [TAG_W-1:0] best_tag;

    always_comb begin
        found    = 1'b0;
        best_idx = '0;
        best_tag = '0;
        for (int i = 0; i < N_UNITS; i++) begin
            if (req_i[i] && (!found || is_older(tags_i[i*TAG_W +: TAG_W], best_tag))) begin
                found    = 1'b1;
                best_idx = IDX_W'(i);
                best_tag = tags_i[i*TAG_W +: TAG_W];
            end
        end
        pick_o = '0;
        if (found) pick_o[best_idx] = 1'b1;
    end
endmodule

// File: rtl/result_bus_arbiter.sv
module result_bus_arbiter #(
    parameter int N_UNITS     = 4,
    parameter int MAX_INFLIGHT = 8,
    parameter int TAG_W       = $clog2(MAX_INFLIGHT) + 1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [N_UNITS-1:0]       start_i,
    input  logic [N_UNITS-1:0]       done_i,
    input  logic [N_UNITS-1:0]       need_bus_i,
    input  logic [N_UNITS*TAG_W-1:0] tag_i,
    output logic [N_UNITS-1:0]       grant_o,
    output logic                     bus_valid_o,
    output logic [TAG_W-1:0]         bus_tag_o,
    output logic [N_UNITS-1:0]       free_struct_o,
    output logic [N_UNITS-1:0]       free_bus_o
);
    logic [N_UNITS-1:0]       waiting;
    logic [N_UNITS*TAG_W-1:0] held_tags;
    logic [N_UNITS-1:0]       grant_q;
    logic [N_UNITS-1:0]       pick;

    for (genvar u = 0; u < N_UNITS; u++) begin : g_unit
        rba_unit #(.TAG_W(TAG_W)) i_unit (
            .clk          (clk),
            .rst          (rst),
            .start_i      (start_i[u]),
            .done_i       (done_i[u]),
            .need_bus_i   (need_bus_i[u]),
            .tag_i        (tag_i[u*TAG_W +: TAG_W]),
            .grant_i      (grant_q[u]),
            .waiting_o    (waiting[u]),
            .tag_o        (held_tags[u*TAG_W +: TAG_W]),
            .free_struct_o(free_struct_o[u]),
            .free_bus_o   (free_bus_o[u])
        );
    end

    rba_oldest_pick #(.N_UNITS(N_UNITS), .TAG_W(TAG_W)) i_pick (
        .req_i (waiting & ~grant_q),
        .tags_i(held_tags),
        .pick_o(pick)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            grant_q <= '0;
        end else begin
            grant_q <= pick;
        end
    end

    always_comb begin
        bus_tag_o = '0;
        for (int u = 0; u < N_UNITS; u++) begin
            if (grant_q[u]) bus_tag_o = bus_tag_o | held_tags[u*TAG_W +: TAG_W];
        end
        grant_o     = grant_q;
        bus_valid_o = |grant_q;
    end

    // R1
    grant_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant_q));

    // R8
    reset_clears_grant_chk: assert property (@(posedge clk)
        rst |=> (grant_q == '0));
endmodule

// File: tb/test_result_bus_arbiter.sv
module test_result_bus_arbiter;
    localparam int N = 4;
    localparam int TW = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [N-1:0] start_i = '0, done_i = '0, need_bus_i = '0;
    logic [N*TW-1:0] tag_i = '0;
    logic [N-1:0] grant_o, free_struct_o, free_bus_o;
    logic bus_valid_o;
    logic [TW-1:0] bus_tag_o;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    result_bus_arbiter #(.N_UNITS(N), .MAX_INFLIGHT(8)) i_result_bus_arbiter (
        .clk(clk), .rst(rst), .start_i(start_i), .done_i(done_i),
        .need_bus_i(need_bus_i), .tag_i(tag_i), .grant_o(grant_o),
        .bus_valid_o(bus_valid_o), .bus_tag_o(bus_tag_o),
        .free_struct_o(free_struct_o), .free_bus_o(free_bus_o)
    );

    // Each entry is {tag of unit0, tag of unit1, index of the unit granted first}.
    localparam logic [8:0] VEC [6] = '{
        {4'd3,  4'd5,  1'b0},
        {4'd9,  4'd2,  1'b1},
        {4'd14, 4'd1,  1'b0},
        {4'd1,  4'd14, 1'b1},
        {4'd6,  4'd5,  1'b1},
        {4'd4,  4'd4,  1'b0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic clear_in();
        start_i = '0;
        done_i = '0;
        need_bus_i = '0;
    endtask

    initial begin
        #(4 * 5000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        step(); step();
        rst = 1'b0;
        chk("R8 reset grant", grant_o, 0);
        chk("R8 reset valid", bus_valid_o, 0);
        chk("R8 reset free_struct", free_struct_o, 4'hF);
        chk("R8 reset free_bus", free_bus_o, 4'hF);

        // Table walk: two units finish together, oldest tag broadcasts first.
        foreach (VEC[k]) begin
            logic [TW-1:0] ta, tb;
            int first, second;
            ta = VEC[k][8:5];
            tb = VEC[k][4:1];
            first = VEC[k][0];
            second = 1 - first;
            start_i = 4'b0011; step();
            clear_in();
            done_i = 4'b0011; need_bus_i = 4'b0011;
            tag_i[0 +: TW] = ta; tag_i[TW +: TW] = tb;
            step();
            clear_in();
            chk("R3 busy while waiting", {free_struct_o[1:0], free_bus_o[1:0]}, 0);
            chk("R5 no grant yet", grant_o, 0);
            step();
            chk("R2 first grant", grant_o, 1 << first);
            chk("R5 bus tag", bus_tag_o, first == 0 ? ta : tb);
            chk("R5 struct free in grant cycle", free_struct_o[first], 1);
            chk("R5 bus not free in grant cycle", free_bus_o[first], 0);
            chk("R3 loser still busy", free_struct_o[second], 0);
            step();
            chk("R2 second grant", grant_o, 1 << second);
            chk("R5 bus free after grant", free_bus_o[first], 1);
            step();
            chk("R1 grant idle", {bus_valid_o, grant_o}, 0);
            chk("R5 all free", free_bus_o, 4'hF);
        end

        // R2: three waiters with tags 10,12,9 -> order unit2, unit0, unit1
        start_i = 4'b0111; step();
        clear_in(); done_i = 4'b0111; need_bus_i = 4'b0111;
        tag_i[0 +: TW] = 4'd10; tag_i[TW +: TW] = 4'd12; tag_i[2*TW +: TW] = 4'd9;
        step(); clear_in();
        step(); chk("R2 three-way first", grant_o, 4'b0100);
        step(); chk("R2 three-way second", grant_o, 4'b0001);
        step(); chk("R2 three-way third", grant_o, 4'b0010);
        chk("R1 valid with grant", bus_valid_o, 1);
        step();

        // R4: result-less finish releases directly
        start_i = 4'b1000; step();
        clear_in(); done_i = 4'b1000; need_bus_i = 4'b0000; step();
        clear_in();
        chk("R4 free_struct after release", free_struct_o[3], 1);
        chk("R4 free_bus after release", free_bus_o[3], 1);
        step();
        chk("R4 no grant for no-result", grant_o, 0);

        // R6: start accepted in grant cycle
        start_i = 4'b0100; step();
        clear_in(); done_i = 4'b0100; need_bus_i = 4'b0100; tag_i[2*TW +: TW] = 4'd3; step();
        clear_in(); step();
        chk("R6 grant present", grant_o, 4'b0100);
        start_i = 4'b0100; step(); clear_in();
        chk("R6 busy again struct", free_struct_o[2], 0);
        chk("R6 busy again bus", free_bus_o[2], 0);
        chk("R6 no grant", grant_o, 0);
        done_i = 4'b0100; need_bus_i = 4'b0000; step(); clear_in();
        chk("R6 released", free_bus_o[2], 1);

        // R7: start on a waiting, not-granted unit is ignored
        start_i = 4'b0011; step();
        clear_in(); done_i = 4'b0011; need_bus_i = 4'b0011;
        tag_i[0 +: TW] = 4'd2; tag_i[TW +: TW] = 4'd6; step();
        clear_in(); step();
        chk("R7 unit0 granted", grant_o, 4'b0001);
        start_i = 4'b0010; step(); clear_in();
        chk("R7 ignored start, unit1 still granted", grant_o, 4'b0010);
        chk("R7 tag of waiting unit", bus_tag_o, 4'd6);
        step();
        chk("R7 unit1 free afterwards", free_bus_o[1], 1);

        // R8: reset in the middle of a wait
        start_i = 4'b0001; step();
        clear_in(); done_i = 4'b0001; need_bus_i = 4'b0001; step();
        clear_in(); rst = 1'b1; step(); rst = 1'b0;
        chk("R8 mid reset grant", grant_o, 0);
        chk("R8 mid reset free", free_bus_o, 4'hF);
        step();
        chk("R8 no late grant", grant_o, 0);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule